// File: doc/BRIEF.md
# Embedded Video Sync Code Decoder

This block watches a parallel camera pixel bus and rebuilds frame and line timing from synchronisation codes that travel inside the data stream. It does not need separate horizontal and vertical sync wires. A code is the fixed run FF, 00, 00 followed by one code byte. That byte is compared against four programmable codes: frame start, frame end, line start and line end. Each code has its own unmask byte, so only the chosen bits take part in the comparison.

The outputs are two registered levels, one for frame-active and one for line-active. Beside them are single-cycle horizontal and vertical event pulses and a single-cycle sync-error pulse. A small write-only configuration port sets the codes, the unmask bytes and the control bits. The control bits choose the sync source and decide whether each event marks the opening or the closing of its interval. In hardware mode the decoder is bypassed and the levels follow the external sync inputs.

Top module: `esync_decoder`

## Requirements
- R1: During and after reset all five outputs are 0, the block is in hardware mode, every unmask bit is 1 and every code is 0.
- R2: A configuration write at address 0 loads the codes, with frame start in bits [7:0], line start in [15:8], line end in [23:16] and frame end in [31:24]. Address 1 loads the unmask bytes in the same lanes. Address 2 loads the control bits: bit 0 selects embedded mode, bit 1 selects line-start horizontal events, bit 2 selects frame-start vertical events. Address 3 is ignored. A write takes effect from the next cycle.
- R3: In embedded mode, a code byte is accepted only as the valid byte that follows valid bytes FF, 00, 00. Cycles with pix_valid_i low are skipped. An FF restarts the run, and any other byte breaks it.
- R4: A code byte matches a code when it equals that code in every bit whose unmask bit is 1. Bits whose unmask bit is 0 are ignored.
- R5: When several codes match, the winner is chosen in the order frame start, frame end, line start, line end.
- R6: The levels change after the clock edge that accepts the code byte. Frame start sets frame-active and clears line-active. Frame end clears both. Line start sets line-active. Line end clears line-active.
- R7: In embedded mode, vs_evt_o pulses for one cycle together with the level change of frame start when control bit 2 is 1. It pulses with frame end when control bit 2 is 0.
- R8: In embedded mode, hs_evt_o pulses for one cycle together with a valid line start when control bit 1 is 1. It pulses with a valid line end when control bit 1 is 0.
- R9: sync_err_o pulses for one cycle when a line start arrives while a line is open, when a line end arrives with no line open, or when a code byte matches no code. On an error the levels are unchanged and no event pulses.
- R10: In hardware mode the levels are the active-high vsync_i and hsync_i, each registered once. Events pulse on the rising or falling edge of the registered level, as the control bits select. Pixel data is ignored and sync_err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 4*CODE_W | Configuration write data |
| pix_valid_i | input | 1 | Pixel byte qualifier |
| pix_data_i | input | CODE_W | Pixel byte |
| hsync_i | input | 1 | External line sync, used in hardware mode |
| vsync_i | input | 1 | External frame sync, used in hardware mode |
| frame_active_o | output | 1 | Frame interval level |
| line_active_o | output | 1 | Line interval level |
| hs_evt_o | output | 1 | Horizontal sync event pulse |
| vs_evt_o | output | 1 | Vertical sync event pulse |
| sync_err_o | output | 1 | Malformed code stream pulse |

## Verification
The bench builds the block with the default CODE_W of 8, which is the byte width of the packed code and unmask words. With 8-bit bytes the sync run FF, 00, 00 and whole code bytes can be written directly. Random codes with partial unmask bytes then produce overlapping matches, so the priority order, the error paths and both event-timing settings are all reached within a few thousand cycles.

// File: rtl/esync_pkg.sv
package esync_pkg;
  localparam int unsigned N_CODES = 4;
  localparam int unsigned ADDR_W  = 2;

  // byte lane of each code inside the packed code and unmask words
  typedef enum logic [1:0] {
    K_FS = 2'd0,
    K_LS = 2'd1,
    K_LE = 2'd2,
    K_FE = 2'd3
  } kind_e;

  typedef struct packed {
    logic vs_at_start;
    logic hs_at_start;
    logic embedded;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CODES = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASKS = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
endpackage

// File: rtl/esync_cfg.sv
module esync_cfg
  import esync_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned CFG_W = N_CODES * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  codes_o,
  output logic [CFG_W-1:0]  masks_o,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      codes_o <= '0;
      masks_o <= '1;
      ctrl_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CODES: codes_o <= wdata_i;
        A_MASKS: masks_o <= wdata_i;
        A_CTRL:  ctrl_o  <= ctrl_t'(wdata_i[2:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/esync_preamble.sv
module esync_preamble #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              code_stb_o
);
  typedef enum logic [1:0] {P_IDLE, P_ONES, P_ZERO1, P_ZERO2} pst_e;

  localparam logic [CODE_W-1:0] ALL_ONES  = '1;
  localparam logic [CODE_W-1:0] ALL_ZEROS = '0;

  pst_e st_q, st_d;

  assign code_stb_o = en_i && valid_i && (st_q == P_ZERO2);

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = P_IDLE;
    end else if (valid_i) begin
      if (st_q == P_ZERO2)           st_d = P_IDLE;
      else if (data_i == ALL_ONES)   st_d = P_ONES;
      else if (data_i == ALL_ZEROS && st_q == P_ONES)  st_d = P_ZERO1;
      else if (data_i == ALL_ZEROS && st_q == P_ZERO1) st_d = P_ZERO2;
      else                           st_d = P_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= P_IDLE;
    else         st_q <= st_d;
  end

  // R3: a fresh run of three bytes is needed between two code bytes
  a_r3_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_stb_o |=> !code_stb_o);
endmodule

// File: rtl/esync_match.sv
module esync_match
  import esync_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned CFG_W = N_CODES * CODE_W
) (
  input  logic [CODE_W-1:0] byte_i,
  input  logic [CFG_W-1:0]  codes_i,
  input  logic [CFG_W-1:0]  masks_i,
  output logic [N_CODES-1:0] sel_o,
  output logic              hit_o,
  output kind_e             kind_o
);
  logic [N_CODES-1:0] raw;

  for (genvar k = 0; k < N_CODES; k++) begin : g_cmp
    assign raw[k] = ((byte_i ^ codes_i[k*CODE_W +: CODE_W])
                     & masks_i[k*CODE_W +: CODE_W]) == '0;
  end

  // priority: frame start, frame end, line start, line end
  always_comb begin
    sel_o  = '0;
    kind_o = K_FS;
    if (raw[K_FS])      kind_o = K_FS;
    else if (raw[K_FE]) kind_o = K_FE;
    else if (raw[K_LS]) kind_o = K_LS;
    else                kind_o = K_LE;
    hit_o = |raw;
    if (hit_o) sel_o[kind_o] = 1'b1;
  end
endmodule

// File: rtl/esync_decoder.sv
module esync_decoder
  import esync_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  localparam int unsigned CFG_W = N_CODES * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              pix_valid_i,
  input  logic [CODE_W-1:0] pix_data_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic              frame_active_o,
  output logic              line_active_o,
  output logic              hs_evt_o,
  output logic              vs_evt_o,
  output logic              sync_err_o
);
  logic [CFG_W-1:0]   codes, masks;
  ctrl_t              ctrl;
  logic               code_stb;
  logic [N_CODES-1:0] sel;
  logic               hit;
  kind_e              kind;

  esync_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .codes_o (codes),
    .masks_o (masks),
    .ctrl_o  (ctrl)
  );

  esync_preamble #(.CODE_W(CODE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.embedded),
    .valid_i    (pix_valid_i),
    .data_i     (pix_data_i),
    .code_stb_o (code_stb)
  );

  esync_match #(.CODE_W(CODE_W)) u_match (
    .byte_i  (pix_data_i),
    .codes_i (codes),
    .masks_i (masks),
    .sel_o   (sel),
    .hit_o   (hit),
    .kind_o  (kind)
  );

  logic frame_d, line_d, hs_d, vs_d, err_d;

  always_comb begin
    frame_d = frame_active_o;
    line_d  = line_active_o;
    hs_d    = 1'b0;
    vs_d    = 1'b0;
    err_d   = 1'b0;
    if (!ctrl.embedded) begin
      frame_d = vsync_i;
      line_d  = hsync_i;
      hs_d = ctrl.hs_at_start ? (hsync_i && !line_active_o) : (!hsync_i && line_active_o);
      vs_d = ctrl.vs_at_start ? (vsync_i && !frame_active_o) : (!vsync_i && frame_active_o);
    end else if (code_stb) begin
      if (!hit) begin
        err_d = 1'b1;
      end else begin
        unique case (kind)
          K_FS: begin
            frame_d = 1'b1;
            line_d  = 1'b0;
            vs_d    = ctrl.vs_at_start;
          end
          K_FE: begin
            frame_d = 1'b0;
            line_d  = 1'b0;
            vs_d    = !ctrl.vs_at_start;
          end
          K_LS: begin
            if (line_active_o) err_d = 1'b1;
            else begin
              line_d = 1'b1;
              hs_d   = ctrl.hs_at_start;
            end
          end
          K_LE: begin
            if (!line_active_o) err_d = 1'b1;
            else begin
              line_d = 1'b0;
              hs_d   = !ctrl.hs_at_start;
            end
          end
          default: err_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_active_o <= 1'b0;
      line_active_o  <= 1'b0;
      hs_evt_o       <= 1'b0;
      vs_evt_o       <= 1'b0;
      sync_err_o     <= 1'b0;
    end else begin
      frame_active_o <= frame_d;
      line_active_o  <= line_d;
      hs_evt_o       <= hs_d;
      vs_evt_o       <= vs_d;
      sync_err_o     <= err_d;
    end
  end

  // R5: at most one winning code
  a_r5_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  // R9: an error cycle carries no event
  a_r9_err_no_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> (!hs_evt_o && !vs_evt_o));

  // R10: hardware mode never reports a code error
  a_r10_hw_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl.embedded) |-> !sync_err_o);

  // R7: frame-start events open the frame, frame-end events close it
  a_r7_vs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_evt_o && $past(ctrl.embedded)) |-> (frame_active_o == $past(ctrl.vs_at_start)));

  // R8: line-start events open the line, line-end events close it
  a_r8_hs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_evt_o && $past(ctrl.embedded)) |-> (line_active_o == $past(ctrl.hs_at_start)));

  // R6: accepted code bytes are the only cause of a level change in embedded mode
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl.embedded) && !$past(code_stb)) |->
      ($stable(frame_active_o) && $stable(line_active_o)));
endmodule

// File: tb/esync_decoder_test.sv
module esync_decoder_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        hsync = 1'b0;
  logic        vsync = 1'b0;
  logic        frame_act, line_act, hs_evt, vs_evt, sync_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state
  logic [31:0] m_codes = '0;
  logic [31:0] m_masks = '1;
  logic        m_emb = 1'b0, m_hss = 1'b0, m_vss = 1'b0;
  logic        m_f = 1'b0, m_l = 1'b0;
  int          m_p = 0;

  always #(CLK_P/2) clk = ~clk;

  esync_decoder uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cfg_we_i       (cfg_we),
    .cfg_addr_i     (cfg_addr),
    .cfg_wdata_i    (cfg_wdata),
    .pix_valid_i    (pix_valid),
    .pix_data_i     (pix_data),
    .hsync_i        (hsync),
    .vsync_i        (vsync),
    .frame_active_o (frame_act),
    .line_active_o  (line_act),
    .hs_evt_o       (hs_evt),
    .vs_evt_o       (vs_evt),
    .sync_err_o     (sync_err)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // priority order frame start(0), frame end(3), line start(1), line end(2)
  function automatic int f_match(input logic [7:0] b);
    int order [4] = '{0, 3, 1, 2};
    for (int i = 0; i < 4; i++) begin
      if (((b ^ m_codes[order[i]*8 +: 8]) & m_masks[order[i]*8 +: 8]) == 8'h00)
        return order[i];
    end
    return 4;
  endfunction

  task automatic do_cycle(input logic v, input logic [7:0] d, input logic hs, input logic vs,
                          input logic we, input logic [1:0] addr, input logic [31:0] wd,
                          input string tag);
    logic ef, el, eh, ev, ee;
    int   np, k;
    pix_valid = v; pix_data = d; hsync = hs; vsync = vs;
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    ef = m_f; el = m_l; eh = 1'b0; ev = 1'b0; ee = 1'b0; np = m_p;
    if (!m_emb) begin
      ef = vs; el = hs;
      eh = m_hss ? (hs && !m_l) : (!hs && m_l);
      ev = m_vss ? (vs && !m_f) : (!vs && m_f);
      np = 0;
    end else if (v) begin
      if (m_p == 3) begin
        np = 0;
        k = f_match(d);
        case (k)
          0: begin ef = 1'b1; el = 1'b0; ev = m_vss; end
          3: begin ef = 1'b0; el = 1'b0; ev = !m_vss; end
          1: if (m_l) ee = 1'b1; else begin el = 1'b1; eh = m_hss; end
          2: if (!m_l) ee = 1'b1; else begin el = 1'b0; eh = !m_hss; end
          default: ee = 1'b1;
        endcase
      end else if (d == 8'hFF) np = 1;
      else if (d == 8'h00 && m_p > 0) np = m_p + 1;
      else np = 0;
    end
    @(posedge clk);
    if (we) begin
      case (addr)
        2'd0: m_codes = wd;
        2'd1: m_masks = wd;
        2'd2: {m_vss, m_hss, m_emb} = wd[2:0];
        default: ;
      endcase
    end
    m_f = ef; m_l = el; m_p = np;
    @(negedge clk);
    chk(frame_act, ef, tag, "frame_active (R6/R10)");
    chk(line_act,  el, tag, "line_active (R6/R10)");
    chk(hs_evt,    eh, tag, "hs_evt (R8)");
    chk(vs_evt,    ev, tag, "vs_evt (R7)");
    chk(sync_err,  ee, tag, "sync_err (R9)");
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input string tag);
    do_cycle(v, d, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] w, input string tag);
    do_cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, a, w, tag);
  endtask

  task automatic send_code(input logic [7:0] c, input string tag);
    cyc(1'b1, 8'hFF, tag);
    cyc(1'b1, 8'h00, tag);
    cyc(1'b1, 8'h00, tag);
    cyc(1'b1, c, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    chk(frame_act, 1'b0, "R1", "frame_active in reset");
    chk(line_act,  1'b0, "R1", "line_active in reset");
    chk(hs_evt,    1'b0, "R1", "hs_evt in reset");
    chk(vs_evt,    1'b0, "R1", "vs_evt in reset");
    chk(sync_err,  1'b0, "R1", "sync_err in reset");
    rst_ni = 1'b1;
    // R1: default is hardware mode, line level follows hsync
    do_cycle(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "R1");
    do_cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "R1");

    // R10: hardware mode under random sync, random data and both edge selections
    for (int r = 0; r < 4; r++) begin
      wr(2'd2, {29'd0, r[1:0], 1'b0}, "R10");
      for (int i = 0; i < 60; i++)
        do_cycle($urandom_range(1, 0) == 1, 8'($urandom), $urandom_range(1, 0) == 1,
                 $urandom_range(3, 0) == 0, 1'b0, 2'd0, 32'd0, "R10");
    end
    // R10: a code run in hardware mode raises nothing
    send_code(8'h11, "R10");

    // R2: program codes, full masks, embedded with start-side events
    wr(2'd0, 32'hB69D80AB, "R2");
    wr(2'd1, 32'hFFFFFFFF, "R2");
    wr(2'd3, 32'h00000000, "R2");
    wr(2'd2, 32'h00000007, "R2");
    send_code(8'hAB, "R6");
    send_code(8'h80, "R6");
    cyc(1'b1, 8'h42, "R6");
    send_code(8'h9D, "R6");
    send_code(8'h80, "R8");
    send_code(8'h9D, "R8");
    send_code(8'hB6, "R7");
    // R7/R8: end-side events
    wr(2'd2, 32'h00000001, "R2");
    send_code(8'hAB, "R7");
    send_code(8'h80, "R8");
    send_code(8'h9D, "R8");
    send_code(8'hB6, "R7");
    // R9: double line start, orphan line end, unknown byte
    send_code(8'hAB, "R9");
    send_code(8'h80, "R9");
    send_code(8'h80, "R9");
    send_code(8'h9D, "R9");
    send_code(8'h9D, "R9");
    send_code(8'h11, "R9");
    // R3: broken run, restarted run, gaps inside a run
    cyc(1'b1, 8'hFF, "R3"); cyc(1'b1, 8'h00, "R3"); cyc(1'b1, 8'h55, "R3");
    cyc(1'b1, 8'h00, "R3"); cyc(1'b1, 8'h80, "R3");
    cyc(1'b1, 8'hFF, "R3"); cyc(1'b1, 8'hFF, "R3"); cyc(1'b1, 8'h00, "R3");
    cyc(1'b1, 8'h00, "R3"); cyc(1'b1, 8'h80, "R3");
    cyc(1'b1, 8'hFF, "R3"); cyc(1'b0, 8'h13, "R3"); cyc(1'b1, 8'h00, "R3");
    cyc(1'b0, 8'hFF, "R3"); cyc(1'b1, 8'h00, "R3"); cyc(1'b0, 8'h00, "R3");
    cyc(1'b1, 8'h9D, "R3");
    // R4: frame-start compares only the top nibble
    wr(2'd1, 32'hFFFFFFF0, "R4");
    send_code(8'hA5, "R4");
    send_code(8'h5B, "R4");
    // R5: every code matches -> frame start; only line codes match -> line start
    wr(2'd1, 32'h00000000, "R5");
    send_code(8'h11, "R5");
    wr(2'd1, 32'hFF0000FF, "R5");
    send_code(8'h11, "R5");
    send_code(8'h11, "R5");

    // random configurations with partial masks
    for (int c = 0; c < 25; c++) begin
      wr(2'd0, $urandom, "R2");
      wr(2'd1, $urandom | $urandom, "R4");
      wr(2'd2, {29'd0, 3'($urandom) | 3'd1}, "R2");
      for (int i = 0; i < 50; i++) begin
        int sel = $urandom_range(9, 0);
        if (sel < 6) begin
          int k = $urandom_range(3, 0);
          logic [7:0] b = m_codes[k*8 +: 8] ^ (8'($urandom) & ~m_masks[k*8 +: 8]);
          if ($urandom_range(3, 0) == 0) cyc(1'b0, 8'hFF, "R3");
          send_code(b, "R4");
        end else if (sel < 8) begin
          send_code(8'($urandom), "R9");
        end else begin
          cyc($urandom_range(1, 0) == 1, 8'($urandom), "R3");
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule